// File: doc/BRIEF.md
# Tagged Split-Transaction Read Interconnect

This block is a small read fabric in which asking for data and getting it back are two separate exchanges. A requester sends a source address and a target address. The request goes into a four-entry address queue. The entry at the head of that queue is decoded against two responder windows. The responder that owns the target waits for its own fixed latency. It then removes the request and writes a four-word burst into a four-entry return queue, tagged with the request's source address.

The master side drains the return queue one word per cycle over a valid/ready stream. The tag travels with every word, and the last word is marked. It only takes a burst whose tag lies in its own window.

Both queues are served strictly from the head. A fast responder's request can therefore never overtake a slow one's. A head request that decodes to neither window is discarded, and this is remembered in a sticky error flag.

Back-pressure rules:
- On the request side, `req_ready` is low exactly while the address queue is full. A request transfers on a cycle where `req_valid` and `req_ready` are both high.
- On the output side, a word transfers on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, tag, word and last flag are held.

Top module: `tagged_read_xbar`

## Requirements
- R1: After reset both queues are empty and not full, `req_ready` is high, `out_valid` is low and `dec_err` is low.
- R2: The address queue holds up to 4 requests. With 4 held, `aq_full` is high, `req_ready` is low and no further request is taken.
- R3: A target in 0x100..0x1FF is served by responder A, whose burst words are 10,11,12,13. A target in 0x200..0x2FF is served by responder B, whose words are 100,101,102,103.
- R4: With the block idle, `rq_empty` falls exactly LAT_A (default 3) cycles after the request transfer edge for responder A, and LAT_B (default 5) cycles after it for responder B.
- R5: Only the head request is ever served. Bursts leave in request order, even when a fast-responder request waits behind a slow one.
- R6: Each burst carries the source address of its request on `out_tag`, on every word.
- R7: While the return queue is full no request is served, and the address queue keeps its entries.
- R8: A burst is four words, word i at the i-th accepted transfer, with `out_last` high only on the fourth. Outputs hold while stalled, and the entry is released only when the last word is accepted.
- R9: A head burst whose tag lies outside 0x300..0x3FF is never presented (`out_valid` stays low) and stays in the return queue.
- R10: A head request whose target lies in neither responder window is discarded one cycle after reaching the head. `dec_err` then goes high and stays high until reset, and later requests are served normally.
- R11: A request transfer in the same cycle a request is served leaves the address-queue occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Address queue can take a request |
| req_src | input | 12 | Source address of the request (becomes the tag) |
| req_dst | input | 12 | Target address of the request |
| out_valid | output | 1 | Burst word offered to the master |
| out_ready | input | 1 | Master accepts the word |
| out_tag | output | 12 | Tag of the burst being delivered |
| out_data | output | 8 | Current burst word |
| out_last | output | 1 | Current word is the fourth of the burst |
| aq_full | output | 1 | Address queue holds 4 requests |
| aq_empty | output | 1 | Address queue holds none |
| rq_full | output | 1 | Return queue holds 4 bursts |
| rq_empty | output | 1 | Return queue holds none |
| dec_err | output | 1 | Sticky: a request with an unmapped target was discarded |

## Verification
A request arriving at the address queue can coincide with a responder taking the head request away. Similarly, a burst can be written into the return queue in the same cycle the master is draining it. The first case is provoked by pushing requests on back-to-back cycles to responder A while its first service completes. It is judged by the edge at which `aq_full` rises: the fifth transfer must fill the queue, not the fourth or sixth. The second arises when bursts are drained while the queue is refilled with the flags and tag order checked. All queued bursts must then come out complete and in request order.

// File: rtl/rdx_pkg.sv
package rdx_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int BEATS  = 4;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    addr_t src;
    addr_t dst;
  } req_t;

  typedef struct packed {
    addr_t             tag;
    word_t [BEATS-1:0] beat;
  } burst_t;
endpackage

// File: rtl/rdx_shift_queue.sv
module rdx_shift_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] wr_pos;

  // on a simultaneous pop the tail slot moves one place forward
  assign wr_pos = pop ? cnt - CW'(1) : cnt;

  always_ff @(posedge clk) begin
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) mem[i] <= mem[i+1];
    end
    if (push) mem[wr_pos[IW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else begin
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[0];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/rdx_responder.sv
module rdx_responder
  import rdx_pkg::*;
#(
  parameter int    LAT  = 3,
  parameter addr_t LO   = 12'h100,
  parameter addr_t HI   = 12'h1FF,
  parameter int    BASE = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  addr_t             head_dst,
  input  logic              blocked,
  output logic              match,
  output logic              fire,
  output word_t [BEATS-1:0] beats
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  assign match = head_valid && (head_dst >= LO) && (head_dst <= HI);
  assign fire  = match && !blocked && (cnt == CW'(LAT - 1));

  // wait counter restarts for every new head; it freezes while blocked
  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!match || fire) cnt <= '0;
    else if (!blocked)      cnt <= cnt + CW'(1);
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_beat
    assign beats[g] = word_t'(BASE + g);
  end
endmodule

// File: rtl/tagged_read_xbar.sv
module tagged_read_xbar
  import rdx_pkg::*;
#(
  parameter int    QDEPTH = 4,
  parameter int    LAT_A  = 3,
  parameter int    LAT_B  = 5,
  parameter addr_t A_LO   = 12'h100,
  parameter addr_t A_HI   = 12'h1FF,
  parameter addr_t B_LO   = 12'h200,
  parameter addr_t B_HI   = 12'h2FF,
  parameter addr_t M_LO   = 12'h300,
  parameter addr_t M_HI   = 12'h3FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_src,
  input  logic [ADDR_W-1:0] req_dst,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_tag,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              aq_full,
  output logic              aq_empty,
  output logic              rq_full,
  output logic              rq_empty,
  output logic              dec_err
);
  localparam int BW = $clog2(BEATS);

  req_t              aq_in, aq_head;
  burst_t            rq_in, rq_head;
  addr_t             aq_head_dst;
  logic              aq_push, aq_pop, rq_push, rq_pop;
  logic              match_a, match_b, fire_a, fire_b, dec_miss;
  word_t [BEATS-1:0] beats_a, beats_b;
  logic [BW-1:0]     beat_q;
  logic              xfer;

  // request side
  assign req_ready   = !aq_full;
  assign aq_push     = req_valid && !aq_full;
  assign aq_in       = '{src: req_src, dst: req_dst};
  assign aq_head_dst = aq_head.dst;

  rdx_shift_queue #(.W($bits(req_t)), .DEPTH(QDEPTH)) aq_i (
    .clk(clk), .rst_n(rst_n), .push(aq_push), .din(aq_in), .pop(aq_pop),
    .dout(aq_head), .full(aq_full), .empty(aq_empty)
  );

  // responders; A has fixed priority on the return-queue write port
  rdx_responder #(.LAT(LAT_A), .LO(A_LO), .HI(A_HI), .BASE(10)) resp_a_i (
    .clk(clk), .rst_n(rst_n), .head_valid(!aq_empty), .head_dst(aq_head.dst),
    .blocked(rq_full), .match(match_a), .fire(fire_a), .beats(beats_a)
  );

  rdx_responder #(.LAT(LAT_B), .LO(B_LO), .HI(B_HI), .BASE(100)) resp_b_i (
    .clk(clk), .rst_n(rst_n), .head_valid(!aq_empty), .head_dst(aq_head.dst),
    .blocked(rq_full || fire_a), .match(match_b), .fire(fire_b), .beats(beats_b)
  );

  assign dec_miss = !aq_empty && !match_a && !match_b;
  assign aq_pop   = fire_a || fire_b || dec_miss;
  assign rq_push  = fire_a || fire_b;
  assign rq_in    = '{tag: aq_head.src, beat: (fire_a ? beats_a : beats_b)};

  always_ff @(posedge clk) begin
    if (!rst_n)        dec_err <= 1'b0;
    else if (dec_miss) dec_err <= 1'b1;
  end

  rdx_shift_queue #(.W($bits(burst_t)), .DEPTH(QDEPTH)) rq_i (
    .clk(clk), .rst_n(rst_n), .push(rq_push), .din(rq_in), .pop(rq_pop),
    .dout(rq_head), .full(rq_full), .empty(rq_empty)
  );

  // master side: word stream from the head burst
  assign out_valid = !rq_empty && (rq_head.tag >= M_LO) && (rq_head.tag <= M_HI);
  assign out_tag   = rq_head.tag;
  assign out_data  = rq_head.beat[beat_q];
  assign out_last  = (beat_q == BW'(BEATS - 1));
  assign xfer      = out_valid && out_ready;
  assign rq_pop    = xfer && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n)    beat_q <= '0;
    else if (xfer) beat_q <= out_last ? '0 : beat_q + BW'(1);
  end
endmodule

// File: rtl/rdx_checker.sv
module rdx_checker
  import rdx_pkg::*;
#(
  parameter addr_t A_LO = 12'h100,
  parameter addr_t A_HI = 12'h1FF,
  parameter addr_t B_LO = 12'h200,
  parameter addr_t B_HI = 12'h2FF,
  parameter addr_t M_LO = 12'h300,
  parameter addr_t M_HI = 12'h3FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_tag,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic              aq_empty,
  input logic              rq_full,
  input logic              dec_err,
  input logic [ADDR_W-1:0] aq_head_dst
);
  logic head_mapped;
  assign head_mapped = ((aq_head_dst >= A_LO) && (aq_head_dst <= A_HI)) ||
                       ((aq_head_dst >= B_LO) && (aq_head_dst <= B_HI));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_tag) && $stable(out_last));

  // R8
  burst_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid);

  // R8
  full_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_full && !(out_valid && out_ready && out_last) |=> rq_full);

  // R7
  no_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_full && !aq_empty && head_mapped |=> !aq_empty);

  // R9
  tag_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_tag >= M_LO) && (out_tag <= M_HI));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |=> dec_err);
endmodule

bind tagged_read_xbar rdx_checker #(
  .A_LO(A_LO), .A_HI(A_HI), .B_LO(B_LO), .B_HI(B_HI), .M_LO(M_LO), .M_HI(M_HI)
) chk_i (.*);

// File: tb/tagged_read_xbar_tb_top.sv
`timescale 1ns/1ps
module tagged_read_xbar_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_src = '0;
  logic [11:0] req_dst = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [11:0] out_tag;
  logic [7:0]  out_data;
  logic        out_last;
  logic        aq_full, aq_empty, rq_full, rq_empty, dec_err;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  tagged_read_xbar dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .out_valid(out_valid),
    .out_ready(out_ready), .out_tag(out_tag), .out_data(out_data),
    .out_last(out_last), .aq_full(aq_full), .aq_empty(aq_empty),
    .rq_full(rq_full), .rq_empty(rq_empty), .dec_err(dec_err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung (act %0d cycles, exp < 50000)", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // returns at the negedge after the transfer edge
  task automatic push(input int src, input int dst);
    int w = 0;
    req_src = 12'(src); req_dst = 12'(dst); req_valid = 1'b1;
    while (!req_ready && w < 300) begin @(negedge clk); w++; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic recv(input int tag, input int base, input string req);
    out_ready = 1'b1;
    for (int b = 0; b < 4; b++) begin
      int w = 0;
      while (!out_valid && w < 300) begin @(negedge clk); w++; end
      chk(out_valid, req, out_valid, 1);
      chk(out_tag == 12'(tag), "R6 tag", out_tag, tag);
      chk(out_data == 8'(base + b), req, out_data, base + b);
      chk(out_last == (b == 3), "R8 last flag", out_last, b == 3);
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  task automatic wait_rq(output int k);
    k = 0;
    while (rq_empty && k < 300) begin @(negedge clk); k++; end
  endtask

  task automatic t_reset();
    do_reset();
    // R1
    chk(aq_empty && !aq_full && rq_empty && !rq_full, "R1 queue flags", {aq_empty, aq_full, rq_empty, rq_full}, 4'b1010);
    chk(req_ready && !out_valid && !dec_err, "R1 ready/valid/err", {req_ready, out_valid, dec_err}, 3'b100);
  endtask

  task automatic t_latency();
    int k;
    do_reset();
    push(12'h300, 12'h120);
    wait_rq(k);
    chk(k == 3, "R4 latency A", k, 3);
    recv(12'h300, 10, "R3 data A");
    chk(rq_empty, "R8 entry freed", rq_empty, 1);
    push(12'h3A5, 12'h2F0);
    wait_rq(k);
    chk(k == 5, "R4 latency B", k, 5);
    recv(12'h3A5, 100, "R3 data B");
  endtask

  task automatic t_order();
    do_reset();
    push(12'h301, 12'h200);
    push(12'h302, 12'h1FF);
    // R5: the slow B request is first, so its burst leads
    recv(12'h301, 100, "R5 first burst");
    recv(12'h302, 10, "R5 second burst");
  endtask

  task automatic t_stall();
    int k;
    do_reset();
    push(12'h310, 12'h150);
    wait_rq(k);
    for (int i = 0; i < 3; i++) begin
      chk(out_valid && out_data == 8'd10 && !out_last, "R8 hold", out_data, 10);
      @(negedge clk);
    end
    recv(12'h310, 10, "R8 after stall");
  endtask

  task automatic t_full();
    int w = 0;
    do_reset();
    for (int i = 0; i < 4; i++) push(12'h300 + i, 12'h100);
    while (!rq_full && w < 300) begin @(negedge clk); w++; end
    chk(rq_full, "R7 return full", rq_full, 1);
    for (int i = 4; i < 8; i++) push(12'h300 + i, 12'h100);
    chk(aq_full && !req_ready, "R2 full stall", {aq_full, req_ready}, 2'b10);
    repeat (10) @(negedge clk);
    chk(aq_full, "R7 no service while full", aq_full, 1);
    for (int i = 0; i < 8; i++) recv(12'h300 + i, 10, "R2 drain");
    chk(aq_empty && rq_empty, "R2 drained", {aq_empty, rq_empty}, 2'b11);
  endtask

  task automatic t_simul();
    do_reset();
    // service of the first request lands on the 4th transfer edge
    for (int i = 0; i < 3; i++) push(12'h320 + i, 12'h100);
    push(12'h323, 12'h100);
    chk(!aq_full, "R11 push+pop keeps count", aq_full, 0);
    push(12'h324, 12'h100);
    chk(aq_full, "R11 fifth transfer fills", aq_full, 1);
    push(12'h325, 12'h100);
    for (int i = 0; i < 6; i++) recv(12'h320 + i, 10, "R11 drain");
    chk(aq_empty && rq_empty, "R11 nothing lost", {aq_empty, rq_empty}, 2'b11);
  endtask

  task automatic t_decerr();
    do_reset();
    chk(!dec_err, "R10 clear", dec_err, 0);
    push(12'h300, 12'h7FF);
    @(negedge clk);
    chk(dec_err && aq_empty && rq_empty, "R10 dropped", {dec_err, aq_empty, rq_empty}, 3'b111);
    push(12'h333, 12'h100);
    recv(12'h333, 10, "R10 later served");
    chk(dec_err, "R10 sticky", dec_err, 1);
  endtask

  task automatic t_badtag();
    int k;
    do_reset();
    push(12'h0AB, 12'h110);
    wait_rq(k);
    out_ready = 1'b1;
    for (int i = 0; i < 10; i++) begin
      chk(!out_valid && !rq_empty, "R9 foreign tag held", {out_valid, rq_empty}, 0);
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  initial begin
    t_reset();
    t_latency();
    t_order();
    t_stall();
    t_full();
    t_simul();
    t_decerr();
    t_badtag();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule